// File: doc/BRIEF.md
# Self-Routing Sort-and-Steer Cell Fabric

This block moves fixed-size cells from eight input lanes to eight output lanes in one pass, with no central arbiter. In any cycle each input lane may offer one cell: a valid flag, a 3-bit output number and a 16-bit payload. The caller guarantees that the active cells in one cycle all name different outputs. The fabric first sorts the cells by output number in a network of two-input compare-and-exchange elements. Empty lanes sort below every real cell, so the active cells end up packed at the top in rising order.

The packed, ordered set then passes through a three-level steering network of two-input, two-output elements. A perfect-shuffle wiring pattern sits in front of each level. Each element reads one bit of the output number carried in the cell, starting with the most significant bit. A 0 sends the cell to the element's upper exit and a 1 to the lower exit. Because the cells arrive packed and in order, no element ever has two cells that want the same exit.

Every sorting level and every steering level ends in a register. A cell therefore leaves the fabric exactly nine cycles after it enters, and a fresh set of cells can enter every cycle.

Top module: `bbf_fabric`

## Requirements
- R1: A valid cell offered on any input with output number d appears on output d, with its payload unchanged, exactly 9 rising clock edges after the edge that accepts it. It is not visible one edge earlier.
- R2: `out_vld[p]` is high only when a cell for output p was accepted 9 edges earlier. All other outputs stay low.
- R3: Under full load (all eight inputs valid, output numbers forming any permutation), all eight cells are delivered to their own outputs in the same cycle.
- R4: Under partial load (any subset of inputs valid, including none), every valid cell is delivered. The output number and payload on an input whose valid flag is low have no effect on any output.
- R5: A synchronous active-high reset discards every cell in flight. From the edge after reset is sampled, all outputs read valid low and payload zero until new cells have passed through the full latency.
- R6: A new set of cells may be offered on every cycle. Sets offered on consecutive cycles are delivered on consecutive cycles without affecting one another.
- R7: The sorting network's output is in non-decreasing order of the key {not valid, output number}. Empty lanes therefore follow all active ones.
- R8: No steering element ever receives two valid cells whose selected output-number bit is equal.
- R9: An output whose valid flag is low carries an all-zero payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 8 | Per-input cell present flag |
| in_dst | input | 24 | Output number of each input, 3 bits per lane, lane i at bits [3i+2:3i] |
| in_data | input | 128 | Payload of each input, 16 bits per lane, lane i at bits [16i+15:16i] |
| out_vld | output | 8 | Per-output cell present flag |
| out_data | output | 128 | Payload of each output, 16 bits per lane, lane p at bits [16p+15:16p] |

## Verification
The fabric is driven with full-load permutations: the identity, the reversal, a scrambled order and a rotation. These separate a correct sort-and-steer from one that only works when cells already sit on their own output. Partial loads test the packing of empty lanes ahead of the steering stage: a single cell, every other lane, two far-apart lanes, a contiguous block with reversed numbers and no cells at all. The idle lanes in these loads carry junk numbers that clash with live ones. The vectors are streamed back to back, a reset is applied while a set is in flight, and a lone cell is then watched one cycle before and at its due cycle to pin down the latency.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

    localparam int unsigned PORTS        = 8;
    localparam int unsigned TAG_W        = $clog2(PORTS);
    localparam int unsigned DATA_W       = 16;
    localparam int unsigned KEY_W        = TAG_W + 1;
    localparam int unsigned HALF         = PORTS / 2;
    localparam int unsigned SORT_STAGES  = TAG_W * (TAG_W + 1) / 2;
    localparam int unsigned ROUTE_STAGES = TAG_W;
    localparam int unsigned LATENCY      = SORT_STAGES + ROUTE_STAGES;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [KEY_W-1:0]  key_t;

    typedef struct packed {
        logic  vld;
        tag_t  dst;
        word_t data;
    } cell_t;

    localparam cell_t EMPTY_CELL = '0;

    // Idle lanes get the top key bit set so they order after every live cell.
    function automatic key_t sort_key(cell_t c);
        return {~c.vld, c.dst};
    endfunction

    // Bitonic schedule: phase p merges blocks of 2^p, stepping distance down.
    function automatic int unsigned stage_block(int unsigned s);
        int unsigned cnt;
        int unsigned res;
        cnt = 0;
        res = 0;
        for (int unsigned p = 1; p <= TAG_W; p++) begin
            for (int unsigned q = 0; q < p; q++) begin
                if (cnt == s) res = 32'd1 << p;
                cnt++;
            end
        end
        return res;
    endfunction

    function automatic int unsigned stage_dist(int unsigned s);
        int unsigned cnt;
        int unsigned res;
        cnt = 0;
        res = 0;
        for (int unsigned p = 1; p <= TAG_W; p++) begin
            for (int unsigned q = 0; q < p; q++) begin
                if (cnt == s) res = 32'd1 << (p - 1 - q);
                cnt++;
            end
        end
        return res;
    endfunction

    // Perfect shuffle: rotate the lane index left by one bit.
    function automatic int unsigned shuffle_pos(int unsigned i);
        return ((i << 1) | (i >> (TAG_W - 1))) & (PORTS - 1);
    endfunction

endpackage

// File: rtl/bbf_cmp_swap.sv
module bbf_cmp_swap
    import bbf_pkg::*;
#(
    parameter bit ASCEND = 1'b1
) (
    input  cell_t a_in,
    input  cell_t b_in,
    output cell_t top_out,
    output cell_t bot_out
);

    key_t ka;
    key_t kb;
    logic swap;

    assign ka = sort_key(a_in);
    assign kb = sort_key(b_in);

    generate
        if (ASCEND) begin : g_up
            assign swap = (kb < ka);
        end else begin : g_down
            assign swap = (ka < kb);
        end
    endgenerate

    assign top_out = swap ? b_in : a_in;
    assign bot_out = swap ? a_in : b_in;

endmodule

// File: rtl/bbf_sort_net.sv
module bbf_sort_net
    import bbf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cell_t [PORTS-1:0]   cells_in,
    output cell_t [PORTS-1:0]   cells_out
);

    cell_t [PORTS-1:0] lvl [SORT_STAGES+1];

    assign lvl[0] = cells_in;

    generate
        for (genvar s = 0; s < SORT_STAGES; s++) begin : g_stage
            localparam int unsigned BLK  = stage_block(s);
            localparam int unsigned DIST = stage_dist(s);

            cell_t [PORTS-1:0] nxt;
            cell_t [PORTS-1:0] q;

            for (genvar i = 0; i < PORTS; i++) begin : g_lane
                if ((i ^ DIST) > i) begin : g_cmp
                    bbf_cmp_swap #(
                        .ASCEND((i & BLK) == 0)
                    ) u_cs (
                        .a_in   (lvl[s][i]),
                        .b_in   (lvl[s][i ^ DIST]),
                        .top_out(nxt[i]),
                        .bot_out(nxt[i ^ DIST])
                    );
                end
            end

            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= nxt;
            end

            assign lvl[s+1] = q;
        end
    endgenerate

    assign cells_out = lvl[SORT_STAGES];

endmodule

// File: rtl/bbf_route_elem.sv
module bbf_route_elem
    import bbf_pkg::*;
#(
    parameter int unsigned BIT = 0
) (
    input  cell_t up_in,
    input  cell_t lo_in,
    output cell_t up_out,
    output cell_t lo_out,
    output logic  clash
);

    always_comb begin
        up_out = EMPTY_CELL;
        lo_out = EMPTY_CELL;
        if (lo_in.vld) begin
            if (lo_in.dst[BIT]) lo_out = lo_in;
            else                up_out = lo_in;
        end
        if (up_in.vld) begin
            if (up_in.dst[BIT]) lo_out = up_in;
            else                up_out = up_in;
        end
    end

    assign clash = up_in.vld && lo_in.vld && (up_in.dst[BIT] == lo_in.dst[BIT]);

endmodule

// File: rtl/bbf_route_net.sv
module bbf_route_net
    import bbf_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  cell_t [PORTS-1:0]             cells_in,
    output cell_t [PORTS-1:0]             cells_out,
    output logic [ROUTE_STAGES*HALF-1:0]  clash
);

    cell_t [PORTS-1:0] lvl [ROUTE_STAGES+1];

    assign lvl[0] = cells_in;

    generate
        for (genvar s = 0; s < ROUTE_STAGES; s++) begin : g_stage
            localparam int unsigned BIT = TAG_W - 1 - s;

            cell_t [PORTS-1:0] shuf;
            cell_t [PORTS-1:0] nxt;
            cell_t [PORTS-1:0] q;

            for (genvar i = 0; i < PORTS; i++) begin : g_wire
                assign shuf[shuffle_pos(i)] = lvl[s][i];
            end

            for (genvar e = 0; e < HALF; e++) begin : g_elem
                bbf_route_elem #(
                    .BIT(BIT)
                ) u_el (
                    .up_in (shuf[2*e]),
                    .lo_in (shuf[2*e+1]),
                    .up_out(nxt[2*e]),
                    .lo_out(nxt[2*e+1]),
                    .clash (clash[s*HALF + e])
                );
            end

            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= nxt;
            end

            assign lvl[s+1] = q;
        end
    endgenerate

    assign cells_out = lvl[ROUTE_STAGES];

endmodule

// File: rtl/bbf_fabric.sv
module bbf_fabric
    import bbf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PORTS-1:0]           in_vld,
    input  logic [PORTS*TAG_W-1:0]     in_dst,
    input  logic [PORTS*DATA_W-1:0]    in_data,
    output logic [PORTS-1:0]           out_vld,
    output logic [PORTS*DATA_W-1:0]    out_data
);

    cell_t [PORTS-1:0]               entry_cells;
    cell_t [PORTS-1:0]               sorted_cells;
    cell_t [PORTS-1:0]               routed_cells;
    logic [ROUTE_STAGES*HALF-1:0]    route_clash;

    // Idle lanes enter as all-zero cells so their fields cannot leak out.
    generate
        for (genvar i = 0; i < PORTS; i++) begin : g_in
            assign entry_cells[i] = in_vld[i]
                ? cell_t'{vld: 1'b1, dst: in_dst[i*TAG_W +: TAG_W], data: in_data[i*DATA_W +: DATA_W]}
                : EMPTY_CELL;
        end
    endgenerate

    bbf_sort_net u_sort (
        .clk      (clk),
        .rst      (rst),
        .cells_in (entry_cells),
        .cells_out(sorted_cells)
    );

    bbf_route_net u_route (
        .clk      (clk),
        .rst      (rst),
        .cells_in (sorted_cells),
        .cells_out(routed_cells),
        .clash    (route_clash)
    );

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_out
            assign out_vld[p]                     = routed_cells[p].vld;
            assign out_data[p*DATA_W +: DATA_W]   = routed_cells[p].data;
        end
    endgenerate

endmodule

// File: rtl/bbf_fabric_chk.sv
module bbf_fabric_chk
    import bbf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PORTS-1:0]           in_vld,
    input  logic [PORTS*TAG_W-1:0]     in_dst,
    input  logic [PORTS-1:0]           out_vld,
    input  logic [PORTS*DATA_W-1:0]    out_data,
    input  cell_t [PORTS-1:0]          sorted,
    input  logic [ROUTE_STAGES*HALF-1:0] clash
);

    logic [PORTS-1:0] want;
    logic [PORTS-1:0] want_dly [LATENCY];
    logic             ordered;
    logic             idle_quiet;

    always_comb begin
        want = '0;
        for (int i = 0; i < PORTS; i++) begin
            if (in_vld[i]) want[in_dst[i*TAG_W +: TAG_W]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LATENCY; k++) want_dly[k] <= '0;
        end else begin
            want_dly[0] <= want;
            for (int k = 1; k < LATENCY; k++) want_dly[k] <= want_dly[k-1];
        end
    end

    always_comb begin
        ordered = 1'b1;
        for (int i = 0; i < PORTS - 1; i++) begin
            if (sort_key(sorted[i]) > sort_key(sorted[i+1])) ordered = 1'b0;
        end
    end

    always_comb begin
        idle_quiet = 1'b1;
        for (int p = 0; p < PORTS; p++) begin
            if (!out_vld[p] && (out_data[p*DATA_W +: DATA_W] != '0)) idle_quiet = 1'b0;
        end
    end

    // R2
    delivery_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld == want_dly[LATENCY-1]);

    // R7
    sorted_order_chk: assert property (@(posedge clk) disable iff (rst)
        ordered);

    // R8
    no_clash_chk: assert property (@(posedge clk) disable iff (rst)
        clash == '0);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        idle_quiet);

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (out_vld == '0 && out_data == '0));

endmodule

bind bbf_fabric bbf_fabric_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_dst  (in_dst),
    .out_vld (out_vld),
    .out_data(out_data),
    .sorted  (sorted_cells),
    .clash   (route_clash)
);

// File: tb/sim_bbf_fabric.sv
`timescale 1ns/1ps
module sim_bbf_fabric;

    localparam int N   = 8;
    localparam int TW  = 3;
    localparam int DW  = 16;
    localparam int LAT = 9;
    localparam int NV  = 9;

    // Stimulus table: valid mask, output number per input lane, requirement tag.
    localparam logic [7:0] V_MASK [NV] = '{
        8'hFF, 8'hFF, 8'hFF, 8'h20, 8'h55, 8'h00, 8'h0A, 8'h3F, 8'hFF };
    localparam int V_DST [NV][N] = '{
        '{0,1,2,3,4,5,6,7},   // R3 identity
        '{7,6,5,4,3,2,1,0},   // R3 reversal
        '{3,6,0,5,1,7,2,4},   // R3 scrambled
        '{6,6,6,6,6,2,6,6},   // R1 lone cell, idle lanes clash with each other
        '{7,7,5,5,3,3,1,1},   // R4 alternate lanes, idle lanes reuse live numbers
        '{1,2,3,4,5,6,7,0},   // R4 nothing valid
        '{0,0,0,7,0,7,0,0},   // R4 two far-apart lanes
        '{5,4,3,2,1,0,5,5},   // R4 contiguous block, reversed numbers
        '{3,4,5,6,7,0,1,2} }; // R3 rotation
    localparam int V_REQ [NV] = '{3,3,3,1,4,4,4,4,3};

    logic              clk = 1'b0;
    logic              rst;
    logic [N-1:0]      in_vld;
    logic [N*TW-1:0]   in_dst;
    logic [N*DW-1:0]   in_data;
    logic [N-1:0]      out_vld;
    logic [N*DW-1:0]   out_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bbf_fabric u0 (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_dst  (in_dst),
        .in_data (in_data),
        .out_vld (out_vld),
        .out_data(out_data)
    );

    function automatic logic [DW-1:0] vec_data(int v, int i);
        return 16'(((v + 1) << 12) | (i << 4) | 5);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        in_vld  = '0;
        in_dst  = '1;
        in_data = {N{16'hBEEF}};
    endtask

    task automatic drive_vec(int v);
        for (int i = 0; i < N; i++) begin
            in_vld[i]              = V_MASK[v][i];
            in_dst[i*TW +: TW]     = 3'(V_DST[v][i]);
            in_data[i*DW +: DW]    = V_MASK[v][i] ? vec_data(v, i) : (16'hDEAD ^ 16'(i));
        end
    endtask

    // Expected outputs derived from the table alone (R1, R2, R3, R4, R9).
    task automatic check_vec(int v);
        for (int p = 0; p < N; p++) begin
            logic          ev;
            logic [DW-1:0] ed;
            ev = 1'b0;
            ed = '0;
            for (int i = 0; i < N; i++) begin
                if (V_MASK[v][i] && V_DST[v][i] == p) begin
                    ev = 1'b1;
                    ed = vec_data(v, i);
                end
            end
            check(out_vld[p] == ev && out_data[p*DW +: DW] == ed,
                  $sformatf("R%0d R2 R9 vector %0d port %0d", V_REQ[v], v, p),
                  {15'd0, out_vld[p], out_data[p*DW +: DW]}, {15'd0, ev, ed});
        end
    endtask

    initial begin
        rst = 1'b1;
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5 reset state
        check(out_vld == '0 && out_data == '0, "R5 reset state",
              {24'd0, out_vld}, 32'd0);
        rst = 1'b0;

        // R6 vectors streamed on consecutive cycles
        for (int c = 0; c < NV + LAT; c++) begin
            @(negedge clk);
            if (c >= LAT) check_vec(c - LAT);
            if (c < NV) drive_vec(c);
            else        drive_idle();
        end

        // R5 reset while a full set is in flight: it must never appear
        @(negedge clk);
        drive_vec(2);
        @(negedge clk);
        drive_idle();
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            check(out_vld == '0 && out_data == '0, "R5 in-flight set discarded",
                  {24'd0, out_vld}, 32'd0);
        end

        // R1 lone cell: absent one cycle early, present at the latency
        drive_vec(3);
        @(negedge clk);
        drive_idle();
        repeat (LAT - 2) @(negedge clk);
        check(out_vld == '0, "R1 not visible one cycle early", {24'd0, out_vld}, 32'd0);
        @(negedge clk);
        check_vec(3);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule